// File: doc/BRIEF.md
# Receive Start-Delimiter Detector and Header Checker

This block sits on the descrambled receive bit stream, after code acquisition. A pulse marks the point where the descrambler has finished initializing. After that pulse the block searches the stream for one of two 16-bit start delimiters, which are bit reversals of each other. Which delimiter appears tells it whether the packet uses the long or the short preamble. A time-out bounds the search. Its limit is picked from the polarity of the first synchronization bit: a ones preamble selects the long limit and a zeros preamble selects the short limit.

Once a delimiter is found, the block collects the 48-bit header: an 8-bit rate code, an 8-bit service byte, a 16-bit length and a 16-bit check word. It verifies the check word with the CCITT CRC-16. A good header is presented on a valid/ready result port, together with the decoded rate. A bad check word or an expired search sets a sticky error bit, pulses a request to restart acquisition, and drops the data-ready output.

Input symbols use valid/ready. The block lowers `sym_ready` in three cases: while the init pulse is high, while a finished header waits for its check, and while a result is held. At any other time it consumes every offered symbol, and it discards symbols when it is not searching or collecting. The result port holds `hdr_valid` and all of its fields steady until `hdr_ready` is seen high at a clock edge.

Top module: `rx_sfd_hdr`

## Requirements
- R1: The long delimiter is 0xF3A0 and the short delimiter is 0x05CF, each received least significant bit first, one bit per accepted symbol on `sym_bits[0]`. A match counts only on the 16th or a later symbol accepted since the init pulse. `hdr_short` reports which delimiter was found (1 = short).
- R2: `hdr_valid` is never raised unless a delimiter was found after the last init pulse and the header check word matched.
- R3: The first symbol accepted after init selects the search limit: a 1 selects `tmo_long` and a 0 selects `tmo_short`. A delimiter that completes on the symbol whose count equals the limit is still accepted.
- R4: Symbols offered before the first init pulse, or after a packet has ended, are consumed and ignored. They never raise `data_rdy` or `hdr_valid`.
- R5: Header bit i is the i-th bit received after the delimiter. The rate code is bits 0-7, the service byte is bits 8-15 and the length is bits 16-31, each field least significant bit first.
- R6: The check word is computed with polynomial 0x1021, preset to 0xFFFF, over header bits 0-31 in receive order. Bits 32-47 carry the ones complement of that remainder, most significant bit first.
- R7: On a check-word mismatch, `err_status[0]` is set, `data_rdy` falls, `acq_restart` pulses for one cycle and the block stops searching until the next init pulse.
- R8: When the accepted symbol count reaches the selected limit without a delimiter, `err_status[1]` is set and `acq_restart` pulses for one cycle.
- R9: The `err_status` bits stay set until a 1 is applied on the matching `err_clr` bit at a clock edge. A new error at the same edge wins over the clear.
- R10: After a short delimiter, every header symbol carries two bits, `sym_bits[0]` first and then `sym_bits[1]`, so the header takes 24 symbols. After a long delimiter it takes 48 symbols.
- R11: `hdr_rate` decodes the rate code as 0x0A→0, 0x14→1, 0x37→2 and 0x6E→3, with `hdr_rate_ok` high. Any other code gives `hdr_rate_ok` = 0. `hdr_len_ext` is bit 7 of the service byte.
- R12: While `hdr_valid` is high and `hdr_ready` is low, every result field stays stable and `sym_ready` is low.
- R13: `data_rdy` rises at the edge that accepts the last delimiter bit. It falls on a check-word error or on an init pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_init | input | 1 | Descrambler-initialized pulse; restarts the search |
| tmo_long | input | TMO_W | Search limit, in symbols, for a ones preamble |
| tmo_short | input | TMO_W | Search limit, in symbols, for a zeros preamble |
| sym_valid | input | 1 | Input symbol valid |
| sym_ready | output | 1 | Input symbol accepted at this edge when high with valid |
| sym_bits | input | LANES | Symbol bits; bit 0 comes first |
| hdr_valid | output | 1 | Header result valid |
| hdr_ready | input | 1 | Result consumer ready |
| hdr_short | output | 1 | Short-preamble packet |
| hdr_rate | output | 2 | Decoded rate index |
| hdr_rate_ok | output | 1 | Rate code is one of the four known values |
| hdr_service | output | 8 | Service byte |
| hdr_len_ext | output | 1 | Length-extension flag (service bit 7) |
| hdr_length | output | 16 | Length field |
| data_rdy | output | 1 | Frame timing established |
| acq_restart | output | 1 | One-cycle request to restart acquisition |
| err_status | output | 2 | Sticky errors: bit 0 check word, bit 1 time-out |
| err_clr | input | 2 | Write-one-to-clear for `err_status` |

## Verification
The assertions run on every cycle and cover the result-port rules. They check that the fields hold and the input stalls while a result waits. They check that a valid result implies `data_rdy`. They check that each error bit rises together with a restart request, and that error bits stay set without a clear. They also check the header counter's single and double steps, and that the search counter and polarity do not move when no symbol is accepted. Only the bench scenarios can show the rest. That covers the two delimiter patterns and the early-match guard, the check-word arithmetic and the header bit positions. It also covers the exact symbol on which the long and short time-outs fire, and that symbols sent without an init pulse are ignored.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

  localparam int SFD_W     = 16;
  localparam int CRC_W     = 16;
  localparam int SIG_W     = 8;
  localparam int SVC_W     = 8;
  localparam int LEN_W     = 16;
  localparam int HDR_BITS  = SIG_W + SVC_W + LEN_W + CRC_W;
  localparam int PROT_BITS = HDR_BITS - CRC_W;

  function automatic logic [SFD_W-1:0] bit_rev(input logic [SFD_W-1:0] v);
    logic [SFD_W-1:0] r;
    for (int i = 0; i < SFD_W; i++) r[i] = v[SFD_W-1-i];
    return r;
  endfunction

  // Long delimiter as a word whose bit 0 arrives first; short is its mirror.
  localparam logic [SFD_W-1:0] SFD_LONG  = 16'hF3A0;
  localparam logic [SFD_W-1:0] SFD_SHORT = bit_rev(SFD_LONG);

  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_HEADER, ST_OUT} rx_state_e;

  // Returns {known, index}.
  function automatic logic [2:0] rate_decode(input logic [SIG_W-1:0] s);
    case (s)
      8'h0A:   return 3'b100;
      8'h14:   return 3'b101;
      8'h37:   return 3'b110;
      8'h6E:   return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/rxh_sfd_match.sv
module rxh_sfd_match
  import rxh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic bit_in,
  input  logic armed,
  output logic hit_long,
  output logic hit_short
);

  logic [SFD_W-1:0] win_q;
  logic [SFD_W-1:0] win_nxt;

  // Newest bit enters at the top, so the first received bit ends up at bit 0.
  assign win_nxt   = {bit_in, win_q[SFD_W-1:1]};
  assign hit_long  = step && armed && (win_nxt == SFD_LONG);
  assign hit_short = step && armed && (win_nxt == SFD_SHORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (clear)  win_q <= '0;
    else if (step)   win_q <= win_nxt;
  end

endmodule

// File: rtl/rxh_tmo_timer.sv
module rxh_tmo_timer
  import rxh_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             bit_in,
  input  logic [TMO_W-1:0] lim_long,
  input  logic [TMO_W-1:0] lim_short,
  output logic             expire,
  output logic             armed
);

  localparam logic [TMO_W-1:0] CNT_MAX  = '1;
  localparam logic [TMO_W-1:0] ARM_FROM = TMO_W'(SFD_W - 1);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_inc;
  logic [TMO_W-1:0] limit;
  logic             pol_q;
  logic             pol_set_q;
  logic             pol_now;

  assign pol_now = pol_set_q ? pol_q : bit_in;
  assign limit   = pol_now ? lim_long : lim_short;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + TMO_W'(1);
  assign expire  = step && (cnt_inc >= limit);
  assign armed   = cnt_q >= ARM_FROM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pol_q     <= 1'b0;
      pol_set_q <= 1'b0;
    end else if (clear) begin
      cnt_q     <= '0;
      pol_q     <= 1'b0;
      pol_set_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_inc;
      if (!pol_set_q) begin
        pol_q     <= bit_in;
        pol_set_q <= 1'b1;
      end
    end
  end

  assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(cnt_q));

  assert_pol_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_set_q && !clear) |=> (pol_set_q && $stable(pol_q)));

endmodule

// File: rtl/rxh_hdr_collect.sv
module rxh_hdr_collect
  import rxh_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             dual,
  input  logic [LANES-1:0] bits_in,
  output logic             full,
  output logic [SIG_W-1:0] sig_f,
  output logic [SVC_W-1:0] svc_f,
  output logic [LEN_W-1:0] len_f,
  output logic             crc_ok
);

  localparam int CW = $clog2(HDR_BITS + 1);
  localparam logic [CW-1:0] CNT_END  = CW'(HDR_BITS);
  localparam logic [CW-1:0] CNT_PROT = CW'(PROT_BITS);

  logic [CW-1:0]       cnt_q, cnt_n;
  logic [HDR_BITS-1:0] hb_q, hb_n;
  logic [CRC_W-1:0]    crc_q, crc_n;
  logic [CRC_W-1:0]    rx_crc;

  assign full = (cnt_q == CNT_END);

  // Store each bit at its arrival index; run the CRC over the protected part.
  always_comb begin
    cnt_n = cnt_q;
    hb_n  = hb_q;
    crc_n = crc_q;
    if (step && !full) begin
      for (int l = 0; l < LANES; l++) begin
        if ((l == 0 || dual) && (cnt_n < CNT_END)) begin
          hb_n[cnt_n] = bits_in[l];
          if (cnt_n < CNT_PROT) crc_n = crc_step(crc_n, bits_in[l]);
          cnt_n = cnt_n + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hb_q  <= '0;
      crc_q <= CRC_SEED;
    end else if (clear) begin
      cnt_q <= '0;
      hb_q  <= '0;
      crc_q <= CRC_SEED;
    end else begin
      cnt_q <= cnt_n;
      hb_q  <= hb_n;
      crc_q <= crc_n;
    end
  end

  // The check word arrives most significant bit first.
  for (genvar k = 0; k < CRC_W; k++) begin : g_crc_bits
    assign rx_crc[CRC_W-1-k] = hb_q[PROT_BITS+k];
  end

  assign crc_ok = (rx_crc == ~crc_q);
  assign sig_f  = hb_q[SIG_W-1:0];
  assign svc_f  = hb_q[SIG_W+SVC_W-1:SIG_W];
  assign len_f  = hb_q[PROT_BITS-1:SIG_W+SVC_W];

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END);

  assert_pair_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dual && !clear && !full) |=> (cnt_q == $past(cnt_q) + CW'(2)));

  assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dual && !clear && !full) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/rx_sfd_hdr.sv
module rx_sfd_hdr
  import rxh_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_init,
  input  logic [TMO_W-1:0] tmo_long,
  input  logic [TMO_W-1:0] tmo_short,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [LANES-1:0] sym_bits,
  output logic             hdr_valid,
  input  logic             hdr_ready,
  output logic             hdr_short,
  output logic [1:0]       hdr_rate,
  output logic             hdr_rate_ok,
  output logic [SVC_W-1:0] hdr_service,
  output logic             hdr_len_ext,
  output logic [LEN_W-1:0] hdr_length,
  output logic             data_rdy,
  output logic             acq_restart,
  output logic [1:0]       err_status,
  input  logic [1:0]       err_clr
);

  rx_state_e        st_q;
  logic             accept, srch_step, hdr_step;
  logic             hit_long, hit_short, sfd_hit;
  logic             expire, armed;
  logic             full, crc_ok;
  logic [SIG_W-1:0] sig_f;
  logic [2:0]       rate_dec;
  logic [1:0]       err_set;
  logic             is_short_q, rdy_q, restart_q;
  logic [1:0]       err_q;

  assign sym_ready = !desc_init &&
                     ((st_q == ST_IDLE) || (st_q == ST_SEARCH) ||
                      ((st_q == ST_HEADER) && !full));
  assign accept    = sym_valid && sym_ready;
  assign srch_step = accept && (st_q == ST_SEARCH);
  assign hdr_step  = accept && (st_q == ST_HEADER);
  assign sfd_hit   = hit_long || hit_short;

  rxh_tmo_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(desc_init), .step(srch_step),
    .bit_in(sym_bits[0]), .lim_long(tmo_long), .lim_short(tmo_short),
    .expire(expire), .armed(armed)
  );

  rxh_sfd_match u_sfd (
    .clk(clk), .rst_n(rst_n), .clear(desc_init), .step(srch_step),
    .bit_in(sym_bits[0]), .armed(armed),
    .hit_long(hit_long), .hit_short(hit_short)
  );

  rxh_hdr_collect #(.LANES(LANES)) u_hdr (
    .clk(clk), .rst_n(rst_n), .clear(desc_init), .step(hdr_step),
    .dual(is_short_q), .bits_in(sym_bits), .full(full),
    .sig_f(sig_f), .svc_f(hdr_service), .len_f(hdr_length), .crc_ok(crc_ok)
  );

  assign err_set[0] = !desc_init && (st_q == ST_HEADER) && full && !crc_ok;
  assign err_set[1] = !desc_init && srch_step && !sfd_hit && expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      is_short_q <= 1'b0;
      rdy_q      <= 1'b0;
      restart_q  <= 1'b0;
      err_q      <= '0;
    end else begin
      restart_q <= 1'b0;
      err_q     <= (err_q & ~err_clr) | err_set;
      if (desc_init) begin
        st_q       <= ST_SEARCH;
        is_short_q <= 1'b0;
        rdy_q      <= 1'b0;
      end else begin
        unique case (st_q)
          ST_SEARCH: if (srch_step) begin
            if (sfd_hit) begin
              st_q       <= ST_HEADER;
              is_short_q <= hit_short;
              rdy_q      <= 1'b1;
            end else if (expire) begin
              st_q      <= ST_IDLE;
              restart_q <= 1'b1;
            end
          end
          ST_HEADER: if (full) begin
            if (crc_ok) begin
              st_q <= ST_OUT;
            end else begin
              st_q      <= ST_IDLE;
              rdy_q     <= 1'b0;
              restart_q <= 1'b1;
            end
          end
          ST_OUT: if (hdr_ready) st_q <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign rate_dec    = rate_decode(sig_f);
  assign hdr_valid   = (st_q == ST_OUT);
  assign hdr_short   = is_short_q;
  assign hdr_rate    = rate_dec[1:0];
  assign hdr_rate_ok = rate_dec[2];
  assign hdr_len_ext = hdr_service[SVC_W-1];
  assign data_rdy    = rdy_q;
  assign acq_restart = restart_q;
  assign err_status  = err_q;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready && !desc_init) |=>
      (hdr_valid && $stable(hdr_length) && $stable(hdr_service) &&
       $stable(hdr_rate) && $stable(hdr_short)));

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !sym_ready);

  assert_valid_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> data_rdy);

  assert_crc_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_status[0]) |-> (acq_restart && !data_rdy));

  assert_tmo_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_status[1]) |-> acq_restart);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status[0] && !err_clr[0]) |=> err_status[0]);

endmodule

// File: tb/rx_sfd_hdr_test.sv
`timescale 1ns/1ps
module rx_sfd_hdr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_init = 1'b0;
  logic [15:0] tmo_long = 16'd144;
  logic [15:0] tmo_short = 16'd72;
  logic        sym_valid = 1'b0;
  logic        sym_ready;
  logic [1:0]  sym_bits = '0;
  logic        hdr_valid;
  logic        hdr_ready = 1'b0;
  logic        hdr_short;
  logic [1:0]  hdr_rate;
  logic        hdr_rate_ok;
  logic [7:0]  hdr_service;
  logic        hdr_len_ext;
  logic [15:0] hdr_length;
  logic        data_rdy;
  logic        acq_restart;
  logic [1:0]  err_status;
  logic [1:0]  err_clr = '0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  rx_sfd_hdr uut (
    .clk(clk), .rst_n(rst_n), .desc_init(desc_init),
    .tmo_long(tmo_long), .tmo_short(tmo_short),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_bits(sym_bits),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_short(hdr_short),
    .hdr_rate(hdr_rate), .hdr_rate_ok(hdr_rate_ok), .hdr_service(hdr_service),
    .hdr_len_ext(hdr_len_ext), .hdr_length(hdr_length), .data_rdy(data_rdy),
    .acq_restart(acq_restart), .err_status(err_status), .err_clr(err_clr)
  );

  // {short, corrupt, rate code, service, length}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h0A, 8'h00, 16'h0100},
    {1'b0, 1'b0, 8'h14, 8'h04, 16'h1234},
    {1'b1, 1'b0, 8'h37, 8'h00, 16'h0BB8},
    {1'b1, 1'b0, 8'h6E, 8'h80, 16'hFFFF},
    {1'b0, 1'b1, 8'h6E, 8'h00, 16'h0001},
    {1'b1, 1'b1, 8'h14, 8'h00, 16'h0020},
    {1'b0, 1'b0, 8'h55, 8'h00, 16'h0000}
  };

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [31:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [2:0] ref_rate(input logic [7:0] s);
    if (s == 8'h0A) return 3'b100;
    if (s == 8'h14) return 3'b101;
    if (s == 8'h37) return 3'b110;
    if (s == 8'h6E) return 3'b111;
    return 3'b000;
  endfunction

  task automatic send_sym(input logic b0, input logic b1);
    @(negedge clk);
    sym_valid = 1'b1;
    sym_bits  = {b1, b0};
    while (!sym_ready) @(negedge clk);
    @(posedge clk);
    #1 sym_valid = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); desc_init = 1'b1;
    @(negedge clk); desc_init = 1'b0;
  endtask

  task automatic send_packet(input bit do_init, input bit sh, input int prelen,
                             input logic [7:0] sig, input logic [7:0] svc,
                             input logic [15:0] len, input bit corrupt,
                             input bit chk_rdy);
    logic [15:0] pat;
    logic [47:0] h;
    logic [15:0] c;
    if (do_init) pulse_init();
    for (int i = 0; i < prelen; i++) send_sym(!sh, 1'b0);
    pat = sh ? 16'h05CF : 16'hF3A0;
    for (int i = 0; i < 16; i++) send_sym(pat[i], 1'b0);
    if (chk_rdy) begin
      @(negedge clk);
      cmp("R13", "data_rdy after delimiter", data_rdy, 1);
    end
    h[31:0] = {len, svc, sig};
    c = ref_crc(h[31:0]);
    for (int k = 0; k < 16; k++) h[32+k] = ~c[15-k];
    if (corrupt) h[40] = ~h[40];
    if (sh) for (int j = 0; j < 24; j++) send_sym(h[2*j], h[2*j+1]);
    else    for (int j = 0; j < 48; j++) send_sym(h[j], 1'b0);
  endtask

  task automatic get_result(output bit sv, output bit sa);
    sv = 0; sa = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (hdr_valid) sv = 1;
      if (acq_restart) sa = 1;
      if (sv || sa) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit sv, sa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R2", "reset hdr_valid", hdr_valid, 0);
    cmp("R13", "reset data_rdy", data_rdy, 0);
    cmp("R9", "reset err_status", err_status, 0);
    cmp("R8", "reset acq_restart", acq_restart, 0);
    cmp("R12", "reset sym_ready", sym_ready, 1);

    // Table walk: default preamble lengths land the delimiter on the limit (R3).
    for (int v = 0; v < NV; v++) begin
      logic sh, cor;
      logic [7:0] sg, sv8;
      logic [15:0] ln;
      logic [2:0] rr;
      {sh, cor, sg, sv8, ln} = VEC[v];
      send_packet(1, sh, sh ? 56 : 128, sg, sv8, ln, cor, 1);
      get_result(sv, sa);
      if (!cor) begin
        rr = ref_rate(sg);
        cmp("R3", "valid at limit boundary", sv, 1);
        cmp("R1", "hdr_short", hdr_short, sh);
        cmp("R11", "hdr_rate", hdr_rate, rr[1:0]);
        cmp("R11", "hdr_rate_ok", hdr_rate_ok, rr[2]);
        cmp("R5", "hdr_service", hdr_service, sv8);
        cmp("R5", "hdr_length", hdr_length, ln);
        cmp("R11", "hdr_len_ext", hdr_len_ext, sv8[7]);
        cmp("R6", "no error", err_status, 0);
        @(negedge clk);
        cmp("R12", "held valid", hdr_valid, 1);
        cmp("R12", "held length", hdr_length, ln);
        cmp("R12", "stalled input", sym_ready, 0);
        hdr_ready = 1'b1;
        @(negedge clk);
        hdr_ready = 1'b0;
        cmp("R12", "released", hdr_valid, 0);
      end else begin
        cmp("R2", "no valid on bad check word", sv, 0);
        cmp("R7", "restart pulse", sa, 1);
        cmp("R7", "crc error bit", err_status[0], 1);
        cmp("R7", "data_rdy dropped", data_rdy, 0);
        @(negedge clk);
        cmp("R7", "restart one cycle", acq_restart, 0);
        err_clr = 2'b01;
        @(negedge clk);
        err_clr = 2'b00;
        cmp("R9", "crc error cleared", err_status[0], 0);
      end
    end

    // Long time-out: ones select tmo_long (R3, R8).
    pulse_init();
    for (int i = 0; i < 143; i++) send_sym(1'b1, 1'b0);
    @(negedge clk);
    cmp("R8", "no timeout before long limit", {acq_restart, err_status[1]}, 0);
    send_sym(1'b1, 1'b0);
    @(negedge clk);
    cmp("R8", "restart at long limit", acq_restart, 1);
    cmp("R3", "timeout bit at long limit", err_status[1], 1);
    repeat (3) @(negedge clk);
    cmp("R9", "timeout bit sticky", err_status[1], 1);
    err_clr = 2'b10;
    @(negedge clk);
    err_clr = 2'b00;
    cmp("R9", "timeout bit cleared", err_status[1], 0);

    // Short time-out: zeros select tmo_short.
    pulse_init();
    for (int i = 0; i < 71; i++) send_sym(1'b0, 1'b0);
    @(negedge clk);
    cmp("R3", "no timeout before short limit", {acq_restart, err_status[1]}, 0);
    send_sym(1'b0, 1'b0);
    @(negedge clk);
    cmp("R3", "restart at short limit", acq_restart, 1);
    cmp("R8", "timeout bit at short limit", err_status[1], 1);

    // Whole packet without an init pulse is ignored (R4).
    send_packet(0, 0, 128, 8'h0A, 8'h00, 16'h0042, 0, 0);
    get_result(sv, sa);
    cmp("R4", "no valid without init", sv, 0);
    cmp("R4", "data_rdy without init", data_rdy, 0);

    // Delimiter tail right after init must not match before 16 symbols (R1).
    pulse_init();
    for (int i = 4; i < 16; i++) send_sym(16'hF3A0 >> i, 1'b0);
    @(negedge clk);
    cmp("R1", "early partial delimiter ignored", data_rdy, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule